// File: doc/BRIEF.md
# Microcontroller I/O Register Space

This block holds the peripheral register space of a small 8-bit microcontroller core and decodes the two ways the core can address it. A short I/O view covers 64 locations, 0x00 to 0x3F. A data-space view shows the same locations shifted up by 0x20. Beyond them, from 0x60 to 0xFF, lies an extended region that only data-space loads and stores can reach. The block contains three general-purpose storage registers and one demonstration status register. The status register holds three hardware flags, and software clears a flag by writing a one to its bit.

A single request bus carries byte reads and writes for both views. A `bus_space` bit picks the view: 0 is the I/O view and 1 is the data view. A separate bit-operation port carries single-bit set, clear and test requests for the low 32 I/O locations. On the status register a set writes a one to the named bit only. The other flags are never rewritten, so a flag in another bit position cannot be cleared by accident.

Two small response state machines produce every output from registered state. The bus machine has the states RSP_IDLE, RSP_DATA and RSP_NOSEL:
- A selected read moves it from RSP_IDLE to RSP_DATA.
- Any unselected access moves it to RSP_NOSEL.
- A selected write, or no request, returns it to RSP_IDLE.

The bit machine has the states BIT_IDLE, BIT_DONE, BIT_TEST and BIT_REJECT:
- An accepted set or clear goes to BIT_DONE.
- An accepted test goes to BIT_TEST.
- A request outside the low range goes to BIT_REJECT.
- No request returns it to BIT_IDLE.

Every state lasts one cycle.

Top module: `iorf_space`

## Requirements
- R1: After reset all storage reads as 0x00, and `bus_rvalid`, `bus_nosel`, `bop_valid`, `bop_err` and `bop_result` are low.
- R2: In the I/O view (`bus_space`=0), addresses 0x00 to 0x3F are selected. Any higher address, including the extended region, is not selected and raises `bus_nosel` for one cycle, one cycle after the request.
- R3: In the data view (`bus_space`=1), data address N+0x20 reaches the same register as I/O address N, for N from 0x00 to 0x3F.
- R4: Data addresses 0x60 to 0xFF are selected in the data view. They are reserved: they read 0x00 and ignore writes. Data addresses below 0x20 or above 0xFF are not selected and raise `bus_nosel` one cycle later.
- R5: A selected read returns `bus_rdata` with `bus_rvalid` high for exactly one cycle, one cycle after the request. `bus_rvalid` and `bus_nosel` are never high together.
- R6: Three full 8-bit read/write registers sit at I/O addresses 0x1E, 0x2A and 0x2B.
- R7: The register at I/O address 0x15 holds flags in bits [2:0], and bits [7:3] read as zero. `hw_evt[k]` sets flag k. A bus write of 1 to bit k clears flag k, and a write of 0 leaves it unchanged.
- R8: If `hw_evt[k]` arrives in the same cycle as a clear of flag k, the flag stays set.
- R9: `bop_kind` encodes 2'b01 as set, 2'b10 as clear, 2'b11 as test and 2'b00 as no request. On a register inside 0x00 to 0x1F, a set or clear changes only bit `bop_bit`.
- R10: A bit set on a status flag clears only that flag. A bit clear on a status flag has no effect.
- R11: A bit test raises `bop_valid` one cycle after the request, with `bop_result` equal to the addressed bit. A reserved location tests as 0.
- R12: A bit request to I/O address 0x20 to 0x3F raises `bop_valid` and `bop_err` one cycle later and changes no state.
- R13: A write to a reserved I/O address changes no register, and a reserved address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request |
| bus_space | input | 1 | View select: 0 = I/O view, 1 = data view |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Access address in the chosen view |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after request |
| bus_nosel | output | 1 | Access not decoded by this block |
| bop_req | input | 1 | Bit-operation request |
| bop_kind | input | 2 | 01 set, 10 clear, 11 test |
| bop_addr | input | 6 | I/O address of the bit operation |
| bop_bit | input | 3 | Bit position |
| bop_result | output | 1 | Tested bit value |
| bop_valid | output | 1 | Bit operation completed |
| bop_err | output | 1 | Bit operation rejected (address out of range) |
| hw_evt | input | 3 | Hardware events setting the status flags |

## Verification
The hardest situation to reach is a write-one-to-clear flag that is disturbed by an operation aimed at a different bit. With all three flags clear, a read-modify-write bug would go unnoticed. The bench therefore first pulses all three event inputs to set every flag. It then issues bit sets and clears on single positions of the status register and reads the whole register back after each one. It also drives an event and a clearing write in the same cycle to show that the event wins.

// File: rtl/iorf_pkg.sv
package iorf_pkg;

    localparam int IO_SPAN   = 64;
    localparam int DS_OFFSET = 32;
    localparam int EXT_LO    = 96;
    localparam int EXT_HI    = 255;
    localparam int BIT_SPAN  = 32;
    localparam int NGPR      = 3;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_GPR0 = 3'd1,
        TGT_GPR1 = 3'd2,
        TGT_GPR2 = 3'd3,
        TGT_STAT = 3'd4,
        TGT_RSVD = 3'd5
    } tgt_e;

    typedef enum logic [1:0] {
        BOP_NONE = 2'b00,
        BOP_SET  = 2'b01,
        BOP_CLR  = 2'b10,
        BOP_TEST = 2'b11
    } bop_e;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_DATA,
        RSP_NOSEL
    } bus_state_e;

    typedef enum logic [1:0] {
        BIT_IDLE,
        BIT_DONE,
        BIT_TEST,
        BIT_REJECT
    } bit_state_e;

endpackage

// File: rtl/iorf_decode.sv
module iorf_decode
    import iorf_pkg::*;
#(
    parameter int AW      = 16,
    parameter int GPR0_IO = 'h1E,
    parameter int GPR1_IO = 'h2A,
    parameter int GPR2_IO = 'h2B,
    parameter int STAT_IO = 'h15
) (
    input  logic          space,
    input  logic [AW-1:0] addr,
    output tgt_e          tgt
);

    localparam logic [AW-1:0] IO_END  = AW'(IO_SPAN);
    localparam logic [AW-1:0] DS_LO   = AW'(DS_OFFSET);
    localparam logic [AW-1:0] DS_END  = AW'(DS_OFFSET + IO_SPAN);
    localparam logic [AW-1:0] X_LO    = AW'(EXT_LO);
    localparam logic [AW-1:0] X_HI    = AW'(EXT_HI);

    logic       in_io;
    logic [5:0] idx;

    always_comb begin
        in_io = 1'b0;
        idx   = addr[5:0];
        tgt   = TGT_NONE;
        if (!space) begin
            in_io = (addr < IO_END);
        end else if (addr >= DS_LO && addr < DS_END) begin
            in_io = 1'b1;
            idx   = addr[5:0] - 6'(DS_OFFSET);
        end else if (addr >= X_LO && addr <= X_HI) begin
            tgt = TGT_RSVD;
        end
        if (in_io) begin
            if (idx == 6'(GPR0_IO))      tgt = TGT_GPR0;
            else if (idx == 6'(GPR1_IO)) tgt = TGT_GPR1;
            else if (idx == 6'(GPR2_IO)) tgt = TGT_GPR2;
            else if (idx == 6'(STAT_IO)) tgt = TGT_STAT;
            else                         tgt = TGT_RSVD;
        end
    end

endmodule

// File: rtl/iorf_regs.sv
module iorf_regs
    import iorf_pkg::*;
#(
    parameter int DW    = 8,
    parameter int NFLAG = 3,
    localparam int BW   = $clog2(DW)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  tgt_e                     wr_tgt,
    input  logic [DW-1:0]            wr_data,
    input  logic                     bop_en,
    input  bop_e                     bop_kind,
    input  tgt_e                     bop_tgt,
    input  logic [BW-1:0]            bop_bit,
    input  logic [NFLAG-1:0]         hw_evt,
    output logic [NGPR-1:0][DW-1:0]  gpr,
    output logic [NFLAG-1:0]         flags
);

    logic [DW-1:0] bit_mask;
    assign bit_mask = DW'(1) << bop_bit;

    for (genvar g = 0; g < NGPR; g++) begin : g_gpr
        localparam tgt_e MY_TGT = tgt_e'(int'(TGT_GPR0) + g);
        logic [DW-1:0] nxt;

        always_comb begin
            nxt = gpr[g];
            if (bop_en && bop_tgt == MY_TGT) begin
                if (bop_kind == BOP_SET)      nxt = gpr[g] | bit_mask;
                else if (bop_kind == BOP_CLR) nxt = gpr[g] & ~bit_mask;
            end else if (wr_en && wr_tgt == MY_TGT) begin
                nxt = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) gpr[g] <= '0;
            else        gpr[g] <= nxt;
        end
    end

    logic [NFLAG-1:0] clr_bus;
    logic [NFLAG-1:0] clr_bit;

    always_comb begin
        clr_bus = '0;
        clr_bit = '0;
        if (wr_en && wr_tgt == TGT_STAT)
            clr_bus = wr_data[NFLAG-1:0];
        if (bop_en && bop_tgt == TGT_STAT && bop_kind == BOP_SET
            && int'(bop_bit) < NFLAG)
            clr_bit = NFLAG'(1) << bop_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= hw_evt | (flags & ~(clr_bus | clr_bit));
    end

endmodule

// File: rtl/iorf_resp.sv
module iorf_resp
    import iorf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic          bus_hit,
    input  logic [DW-1:0] rd_val,
    input  logic          bop_req,
    input  bop_e          bop_kind,
    input  logic          bop_in_range,
    input  logic          bop_val,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_rvalid,
    output logic          bus_nosel,
    output logic          bop_result,
    output logic          bop_valid,
    output logic          bop_err
);

    bus_state_e bus_st, bus_nx;
    bit_state_e bit_st, bit_nx;
    logic [DW-1:0] rdata_q;
    logic          bres_q;

    always_comb begin
        bus_nx = RSP_IDLE;
        if (bus_req) begin
            if (!bus_hit)    bus_nx = RSP_NOSEL;
            else if (!bus_we) bus_nx = RSP_DATA;
        end
    end

    always_comb begin
        bit_nx = BIT_IDLE;
        if (bop_req && bop_kind != BOP_NONE) begin
            if (!bop_in_range)          bit_nx = BIT_REJECT;
            else if (bop_kind == BOP_TEST) bit_nx = BIT_TEST;
            else                        bit_nx = BIT_DONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_st  <= RSP_IDLE;
            bit_st  <= BIT_IDLE;
            rdata_q <= '0;
            bres_q  <= 1'b0;
        end else begin
            bus_st  <= bus_nx;
            bit_st  <= bit_nx;
            rdata_q <= (bus_nx == RSP_DATA) ? rd_val : '0;
            bres_q  <= (bit_nx == BIT_TEST) ? bop_val : 1'b0;
        end
    end

    always_comb begin
        bus_rdata  = '0;
        bus_rvalid = 1'b0;
        bus_nosel  = 1'b0;
        unique case (bus_st)
            RSP_IDLE:  ;
            RSP_DATA: begin
                bus_rvalid = 1'b1;
                bus_rdata  = rdata_q;
            end
            RSP_NOSEL: bus_nosel = 1'b1;
            default:   ;
        endcase
    end

    always_comb begin
        bop_valid  = 1'b0;
        bop_err    = 1'b0;
        bop_result = 1'b0;
        unique case (bit_st)
            BIT_IDLE:   ;
            BIT_DONE:   bop_valid = 1'b1;
            BIT_TEST: begin
                bop_valid  = 1'b1;
                bop_result = bres_q;
            end
            BIT_REJECT: begin
                bop_valid = 1'b1;
                bop_err   = 1'b1;
            end
            default:    ;
        endcase
    end

endmodule

// File: rtl/iorf_space.sv
module iorf_space
    import iorf_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int NFLAG   = 3,
    parameter int GPR0_IO = 'h1E,
    parameter int GPR1_IO = 'h2A,
    parameter int GPR2_IO = 'h2B,
    parameter int STAT_IO = 'h15,
    localparam int BW     = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_space,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             bus_rvalid,
    output logic             bus_nosel,
    input  logic             bop_req,
    input  logic [1:0]       bop_kind,
    input  logic [5:0]       bop_addr,
    input  logic [BW-1:0]    bop_bit,
    output logic             bop_result,
    output logic             bop_valid,
    output logic             bop_err,
    input  logic [NFLAG-1:0] hw_evt
);

    tgt_e bus_tgt;
    tgt_e bop_tgt;
    bop_e kind;
    logic bop_in_range;
    logic bop_en;
    logic [NGPR-1:0][DW-1:0] gpr;
    logic [NFLAG-1:0] stat_flags;
    logic [DW-1:0] bus_val;
    logic [DW-1:0] bop_byte;

    assign kind         = bop_e'(bop_kind);
    assign bop_in_range = (int'(bop_addr) < BIT_SPAN);
    assign bop_en       = bop_req && bop_in_range
                          && (kind == BOP_SET || kind == BOP_CLR);

    iorf_decode #(
        .AW(AW), .GPR0_IO(GPR0_IO), .GPR1_IO(GPR1_IO),
        .GPR2_IO(GPR2_IO), .STAT_IO(STAT_IO)
    ) bus_dec_i (
        .space (bus_space),
        .addr  (bus_addr),
        .tgt   (bus_tgt)
    );

    iorf_decode #(
        .AW(AW), .GPR0_IO(GPR0_IO), .GPR1_IO(GPR1_IO),
        .GPR2_IO(GPR2_IO), .STAT_IO(STAT_IO)
    ) bop_dec_i (
        .space (1'b0),
        .addr  (AW'(bop_addr)),
        .tgt   (bop_tgt)
    );

    iorf_regs #(.DW(DW), .NFLAG(NFLAG)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_req && bus_we),
        .wr_tgt   (bus_tgt),
        .wr_data  (bus_wdata),
        .bop_en   (bop_en),
        .bop_kind (kind),
        .bop_tgt  (bop_tgt),
        .bop_bit  (bop_bit),
        .hw_evt   (hw_evt),
        .gpr      (gpr),
        .flags    (stat_flags)
    );

    function automatic logic [DW-1:0] pick(
        input tgt_e                    t,
        input logic [NGPR-1:0][DW-1:0] g,
        input logic [NFLAG-1:0]        f
    );
        logic [DW-1:0] v;
        case (t)
            TGT_GPR0: v = g[0];
            TGT_GPR1: v = g[1];
            TGT_GPR2: v = g[2];
            TGT_STAT: v = DW'(f);
            default:  v = '0;
        endcase
        return v;
    endfunction

    always_comb begin
        bus_val  = pick(bus_tgt, gpr, stat_flags);
        bop_byte = pick(bop_tgt, gpr, stat_flags);
    end

    iorf_resp #(.DW(DW)) resp_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_req      (bus_req),
        .bus_we       (bus_we),
        .bus_hit      (bus_tgt != TGT_NONE),
        .rd_val       (bus_val),
        .bop_req      (bop_req),
        .bop_kind     (kind),
        .bop_in_range (bop_in_range),
        .bop_val      (bop_byte[bop_bit]),
        .bus_rdata    (bus_rdata),
        .bus_rvalid   (bus_rvalid),
        .bus_nosel    (bus_nosel),
        .bop_result   (bop_result),
        .bop_valid    (bop_valid),
        .bop_err      (bop_err)
    );

endmodule

// File: rtl/iorf_space_chk.sv
module iorf_space_chk #(
    parameter int AW    = 16,
    parameter int NFLAG = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bus_space,
    input logic             bus_we,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_rvalid,
    input logic             bus_nosel,
    input logic             bop_req,
    input logic [1:0]       bop_kind,
    input logic [5:0]       bop_addr,
    input logic             bop_valid,
    input logic             bop_err,
    input logic [NFLAG-1:0] hw_evt,
    input logic [NFLAG-1:0] stat_flags
);

    // R2
    io_high_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_space && int'(bus_addr) >= 64) |=> bus_nosel);

    // R4
    ds_outside_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_space && (int'(bus_addr) < 32 || int'(bus_addr) > 255))
        |=> bus_nosel);

    // R3
    ds_read_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_space && !bus_we && int'(bus_addr) >= 32
         && int'(bus_addr) <= 255) |=> bus_rvalid);

    // R5
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rvalid, bus_nosel}));

    // R5
    rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_req && !bus_we));

    // R11
    bop_valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bop_valid |-> $past(bop_req && bop_kind != 2'b00));

    // R12
    bop_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bop_req && bop_kind != 2'b00 && bop_addr >= 6'd32)
        |=> (bop_valid && bop_err));

    // R8
    evt_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_evt != '0) |=> ((stat_flags & $past(hw_evt)) == $past(hw_evt)));

endmodule

bind iorf_space iorf_space_chk #(.AW(AW), .NFLAG(NFLAG)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_space  (bus_space),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .bus_nosel  (bus_nosel),
    .bop_req    (bop_req),
    .bop_kind   (bop_kind),
    .bop_addr   (bop_addr),
    .bop_valid  (bop_valid),
    .bop_err    (bop_err),
    .hw_evt     (hw_evt),
    .stat_flags (stat_flags)
);

// File: tb/iorf_space_tb.sv
`timescale 1ns/1ps
module iorf_space_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_space = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid, bus_nosel;
    logic        bop_req = 1'b0;
    logic [1:0]  bop_kind = 2'b00;
    logic [5:0]  bop_addr = '0;
    logic [2:0]  bop_bit = '0;
    logic        bop_result, bop_valid, bop_err;
    logic [2:0]  hw_evt = '0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    iorf_space dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_space(bus_space),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_nosel(bus_nosel),
        .bop_req(bop_req), .bop_kind(bop_kind), .bop_addr(bop_addr),
        .bop_bit(bop_bit), .bop_result(bop_result), .bop_valid(bop_valid),
        .bop_err(bop_err), .hw_evt(hw_evt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one bus access; returns at the negedge where its response is visible.
    task automatic bus_op(input bit sp, input bit we, input logic [15:0] a,
                          input logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_space = sp; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input bit sp, input logic [15:0] a, input logic [7:0] exp,
                          input string req);
        bus_op(sp, 1'b0, a, 8'h00);
        chk(bus_rvalid && !bus_nosel && bus_rdata == exp, req,
            {bus_rvalid, bus_nosel, bus_rdata}, {2'b10, exp});
    endtask

    task automatic bit_op(input logic [1:0] k, input logic [5:0] a, input logic [2:0] b);
        @(negedge clk);
        bop_req = 1'b1; bop_kind = k; bop_addr = a; bop_bit = b;
        @(negedge clk);
        bop_req = 1'b0; bop_kind = 2'b00;
    endtask

    task automatic bit_chk(input bit v, input bit e, input bit r, input string req);
        chk(bop_valid == v && bop_err == e && bop_result == r, req,
            {bop_valid, bop_err, bop_result}, {v, e, r});
    endtask

    // {space, we, addr[15:0], wdata[7:0], exp_valid, exp_nosel, exp_rdata[7:0]}
    localparam int NV = 18;
    localparam logic [35:0] VEC [NV] = '{
        {1'b0, 1'b1, 16'h001E, 8'hA5, 1'b0, 1'b0, 8'h00},  // R6 write gpr0
        {1'b0, 1'b0, 16'h001E, 8'h00, 1'b1, 1'b0, 8'hA5},  // R6 R5
        {1'b1, 1'b0, 16'h003E, 8'h00, 1'b1, 1'b0, 8'hA5},  // R3
        {1'b1, 1'b1, 16'h004A, 8'h3C, 1'b0, 1'b0, 8'h00},  // R3 write gpr1
        {1'b0, 1'b0, 16'h002A, 8'h00, 1'b1, 1'b0, 8'h3C},  // R6
        {1'b0, 1'b1, 16'h002B, 8'hC3, 1'b0, 1'b0, 8'h00},  // R6 gpr2
        {1'b1, 1'b0, 16'h004B, 8'h00, 1'b1, 1'b0, 8'hC3},  // R3
        {1'b0, 1'b1, 16'h0040, 8'hFF, 1'b0, 1'b1, 8'h00},  // R2
        {1'b0, 1'b0, 16'h0060, 8'h00, 1'b0, 1'b1, 8'h00},  // R2 ext via io
        {1'b0, 1'b0, 16'h003F, 8'h00, 1'b1, 1'b0, 8'h00},  // R2 top of io
        {1'b1, 1'b0, 16'h0010, 8'h00, 1'b0, 1'b1, 8'h00},  // R4 core regs
        {1'b1, 1'b0, 16'h0100, 8'h00, 1'b0, 1'b1, 8'h00},  // R4 above
        {1'b1, 1'b1, 16'h0080, 8'h77, 1'b0, 1'b0, 8'h00},  // R4 ext write
        {1'b1, 1'b0, 16'h0080, 8'h00, 1'b1, 1'b0, 8'h00},  // R4 ext read
        {1'b1, 1'b0, 16'h00FF, 8'h00, 1'b1, 1'b0, 8'h00},  // R4 top ext
        {1'b0, 1'b1, 16'h0000, 8'hFF, 1'b0, 1'b0, 8'h00},  // R13 rsvd write
        {1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h00},  // R13
        {1'b0, 1'b0, 16'h001E, 8'h00, 1'b1, 1'b0, 8'hA5}   // R13 unchanged
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!bus_rvalid && !bus_nosel && !bop_valid && !bop_err && !bop_result,
            "R1", {bus_rvalid, bus_nosel, bop_valid, bop_err, bop_result}, 0);
        rd_chk(1'b0, 16'h001E, 8'h00, "R1");
        rd_chk(1'b0, 16'h002A, 8'h00, "R1");
        rd_chk(1'b0, 16'h002B, 8'h00, "R1");
        rd_chk(1'b0, 16'h0015, 8'h00, "R1");

        for (int i = 0; i < NV; i++) begin
            logic [35:0] v;
            v = VEC[i];
            bus_op(v[35], v[34], v[33:18], v[17:10]);
            chk(bus_rvalid == v[9] && bus_nosel == v[8]
                && (!v[9] || bus_rdata == v[7:0]), "R2 R3 R4 R6 R13 vector",
                {bus_rvalid, bus_nosel, bus_rdata}, v[9:0]);
        end
        // R5: response lasts one cycle
        bus_op(1'b0, 1'b0, 16'h001E, 8'h00);
        @(negedge clk);
        chk(!bus_rvalid, "R5", bus_rvalid, 0);

        // R7 flags set by events
        @(negedge clk); hw_evt = 3'b111;
        @(negedge clk); hw_evt = 3'b000;
        rd_chk(1'b0, 16'h0015, 8'h07, "R7");
        // R10 set on flag 0 clears only flag 0
        bit_op(2'b01, 6'h15, 3'd0);
        bit_chk(1'b1, 1'b0, 1'b0, "R10");
        rd_chk(1'b0, 16'h0015, 8'h06, "R10");
        // R10 clear on flag 1 no effect
        bit_op(2'b10, 6'h15, 3'd1);
        rd_chk(1'b0, 16'h0015, 8'h06, "R10");
        bit_op(2'b01, 6'h15, 3'd5);
        rd_chk(1'b0, 16'h0015, 8'h06, "R7 reserved bit");
        // R7 write one clears, zero keeps
        bus_op(1'b0, 1'b1, 16'h0015, 8'h04);
        rd_chk(1'b1, 16'h0035, 8'h02, "R7");
        // R8 event wins over clear
        @(negedge clk);
        bus_req = 1'b1; bus_space = 1'b0; bus_we = 1'b1; bus_addr = 16'h0015;
        bus_wdata = 8'h02; hw_evt = 3'b010;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; hw_evt = 3'b000;
        rd_chk(1'b0, 16'h0015, 8'h02, "R8");
        bus_op(1'b0, 1'b1, 16'h0015, 8'hFA);
        rd_chk(1'b0, 16'h0015, 8'h00, "R7 R13");

        // R9 single-bit on gpr0 (A5)
        bit_op(2'b01, 6'h1E, 3'd1);
        rd_chk(1'b0, 16'h001E, 8'hA7, "R9");
        bit_op(2'b10, 6'h1E, 3'd0);
        rd_chk(1'b0, 16'h001E, 8'hA6, "R9");
        // R11 bit test
        bit_op(2'b11, 6'h1E, 3'd2);
        bit_chk(1'b1, 1'b0, 1'b1, "R11");
        bit_op(2'b11, 6'h1E, 3'd0);
        bit_chk(1'b1, 1'b0, 1'b0, "R11");
        bit_op(2'b11, 6'h00, 3'd0);
        bit_chk(1'b1, 1'b0, 1'b0, "R11 reserved");
        @(negedge clk);
        bit_chk(1'b0, 1'b0, 1'b0, "R11 one cycle");
        // R12 out-of-range rejected
        bit_op(2'b01, 6'h2A, 3'd0);
        bit_chk(1'b1, 1'b1, 1'b0, "R12");
        rd_chk(1'b0, 16'h002A, 8'h3C, "R12");
        bit_op(2'b11, 6'h2B, 3'd0);
        bit_chk(1'b1, 1'b1, 1'b0, "R12");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule